// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the peripheral clock. Software sets three configuration fields while the peripheral is switched off: a mode bit choosing standard or fast timing, a duty bit choosing between two fast-mode low/high ratios, and a 12-bit count N. From these the block derives a low time and a high time, both in peripheral-clock cycles. It then drives SCL through an open-drain enable for as long as a run request is present.

The clock starts with a full low phase. It then releases the line and waits until the sampled SCL is actually high, so a slave that holds the clock low stretches the period. Only after that does it count the high phase. At the first cycle of every high phase a one-cycle tick is raised, and a phase output shows that the high phase is being timed. Dropping the run request or the enable, or setting a zero count, leaves SCL released.

Top module: `scl_clkgen`

## Requirements
- R1: After reset `scl_oe`, `scl_high` and `high_tick` are 0, and all configuration fields are zero, so enabling and requesting a run before any write produces no clock.
- R2: A configuration write (`cfg_we`=1) is stored only when `enable`=0; with `enable`=1 the write is ignored and the running period is unchanged.
- R3: With a stored count of 0, SCL stays released (`scl_oe`=0) and no `high_tick` occurs, whatever `enable` and `run` do.
- R4: Standard mode (`cfg_fast`=0): the low phase lasts N cycles and the timed high phase lasts N cycles.
- R5: Fast mode with `cfg_duty`=0: the low phase lasts 2N cycles and the timed high phase N cycles.
- R6: Fast mode with `cfg_duty`=1: the low phase lasts 16N cycles and the timed high phase 9N cycles.
- R7: After a low phase SCL is released, with `scl_oe`=0 and `scl_high`=0. The high phase (`scl_high`=1) begins in the cycle after `scl_in` is first sampled 1, so a line held low by a slave extends the period without shortening the high phase.
- R8: `high_tick` is a one-cycle pulse in the first cycle of each high phase.
- R9: When `run` or `enable` is 0 at a clock edge, the next cycle has `scl_oe`=0 and `scl_high`=0. A later restart begins with a complete low phase.
- R10: In standard mode the duty bit has no effect on the phase lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; locks the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fast | input | 1 | Mode: 0 standard, 1 fast |
| cfg_duty | input | 1 | Fast duty: 0 gives 2:1 low/high, 1 gives 16:9 |
| cfg_count | input | 12 | Period count N |
| run | input | 1 | Request to generate the clock |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Open-drain enable: 1 pulls SCL low |
| scl_high | output | 1 | 1 while the high phase is being timed |
| high_tick | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
The bench holds SCL low from outside for a long stretch. A design that timed the high phase without waiting for the line would show a shortened or missing high phase and a tick while SCL is still low. Writes made while enabled are followed by more full periods, so a design that accepted them would change its low length partway through the run. Zero counts, run withdrawn partway through a low phase, and the duty bit set in standard mode each have their own segment. These expose a clock that does not stop, a resumed low phase that is only partly timed, or a ratio applied in the wrong mode.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_state_e;

  // phase multipliers applied to the period count
  localparam int unsigned STD_LOW_MUL   = 1;
  localparam int unsigned STD_HIGH_MUL  = 1;
  localparam int unsigned FD0_LOW_MUL   = 2;
  localparam int unsigned FD0_HIGH_MUL  = 1;
  localparam int unsigned FD1_LOW_MUL   = 16;
  localparam int unsigned FD1_HIGH_MUL  = 9;
  localparam int unsigned MUL_HEADROOM  = 4;  // log2 of the largest multiplier

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_en,
  input  logic             wr_fast,
  input  logic             wr_duty,
  input  logic [CNT_W-1:0] wr_count,
  output logic             fast_q,
  output logic             duty_q,
  output logic [CNT_W-1:0] count_q
);

  logic             load;
  logic             fast_d;
  logic             duty_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    load    = wr_en && !enable;
    fast_d  = wr_fast;
    duty_d  = wr_duty;
    count_d = wr_count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q  <= 1'b0;
      duty_q  <= 1'b0;
      count_q <= '0;
    end else if (load) begin
      fast_q  <= fast_d;
      duty_q  <= duty_d;
      count_q <= count_d;
    end
  end

  a_r2_locked_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(count_q) && $stable(fast_q) && $stable(duty_q)));

endmodule

// File: rtl/scl_ratio.sv
module scl_ratio #(
  parameter int CNT_W = 12,
  parameter int LEN_W = CNT_W + scl_pkg::MUL_HEADROOM
) (
  input  logic             fast,
  input  logic             duty,
  input  logic [CNT_W-1:0] count,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len
);
  import scl_pkg::*;

  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] lo_mul;
  logic [LEN_W-1:0] hi_mul;

  always_comb begin
    base = LEN_W'(count);
    if (!fast) begin
      lo_mul = LEN_W'(STD_LOW_MUL);
      hi_mul = LEN_W'(STD_HIGH_MUL);
    end else if (!duty) begin
      lo_mul = LEN_W'(FD0_LOW_MUL);
      hi_mul = LEN_W'(FD0_HIGH_MUL);
    end else begin
      lo_mul = LEN_W'(FD1_LOW_MUL);
      hi_mul = LEN_W'(FD1_HIGH_MUL);
    end
    low_len  = base * lo_mul;
    high_len = base * hi_mul;
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             scl_in,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             scl_oe,
  output logic             scl_high,
  output logic             high_tick
);
  import scl_pkg::*;

  scl_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tick_q, tick_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tick_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (active) begin
          state_d = ST_LOW;
          cnt_d   = low_len - LEN_W'(1);
        end
      end
      ST_LOW: begin
        if (!active)       state_d = ST_IDLE;
        else if (cnt_zero) state_d = ST_WAIT;
        else               cnt_d   = cnt_q - LEN_W'(1);
      end
      ST_WAIT: begin
        if (!active) state_d = ST_IDLE;
        else if (scl_in) begin
          state_d = ST_HIGH;
          cnt_d   = high_len - LEN_W'(1);
          tick_d  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!active) state_d = ST_IDLE;
        else if (cnt_zero) begin
          state_d = ST_LOW;
          cnt_d   = low_len - LEN_W'(1);
        end else begin
          cnt_d = cnt_q - LEN_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign scl_oe    = (state_q == ST_LOW);
  assign scl_high  = (state_q == ST_HIGH);
  assign high_tick = tick_q;

  // R7: the high phase is entered only after the line was seen high
  a_r7_high_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_high) |-> $past(scl_in));

  a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !scl_in) |=> !scl_high);

  a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    high_tick |=> !high_tick);

  a_r9_drop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!scl_oe && !scl_high));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic             cfg_fast,
  input  logic             cfg_duty,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             run,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             scl_high,
  output logic             high_tick
);

  localparam int LEN_W = CNT_W + scl_pkg::MUL_HEADROOM;

  logic             rst_n_s;
  logic             fast_q;
  logic             duty_q;
  logic [CNT_W-1:0] count_q;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic             active;

  scl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  scl_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .enable   (enable),
    .wr_en    (cfg_we),
    .wr_fast  (cfg_fast),
    .wr_duty  (cfg_duty),
    .wr_count (cfg_count),
    .fast_q   (fast_q),
    .duty_q   (duty_q),
    .count_q  (count_q)
  );

  scl_ratio #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ratio (
    .fast     (fast_q),
    .duty     (duty_q),
    .count    (count_q),
    .low_len  (low_len),
    .high_len (high_len)
  );

  assign active = enable && run && (count_q != '0);

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .active    (active),
    .scl_in    (scl_in),
    .low_len   (low_len),
    .high_len  (high_len),
    .scl_oe    (scl_oe),
    .scl_high  (scl_high),
    .high_tick (high_tick)
  );

  a_r3_zero_released: assert property (@(posedge clk) disable iff (!rst_n_s)
    (count_q == '0) |-> (!scl_oe && !high_tick));

  a_r8_tick_in_high: assert property (@(posedge clk) disable iff (!rst_n_s)
    high_tick |-> scl_high);

  a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({scl_oe, scl_high}));

endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, cfg_we, cfg_fast, cfg_duty, run, stretch;
  logic [11:0] cfg_count;
  logic        scl_in, scl_oe, scl_high, high_tick;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  int m_state = 0;  // 0 idle, 1 low, 2 wait, 3 high
  int m_left = 0;
  int m_fast = 0, m_duty = 0, m_cnt = 0;
  bit m_tick = 0;

  // measured phase lengths
  int low_run = 0, high_run = 0, last_low = 0, last_high = 0, ticks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = ~scl_oe & ~stretch;

  scl_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_fast(cfg_fast), .cfg_duty(cfg_duty), .cfg_count(cfg_count),
    .run(run), .scl_in(scl_in), .scl_oe(scl_oe), .scl_high(scl_high),
    .high_tick(high_tick)
  );

  task automatic chk(string tag, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lo_len();
    if (m_fast == 0) return m_cnt;
    return (m_duty != 0) ? 16 * m_cnt : 2 * m_cnt;
  endfunction

  function automatic int hi_len();
    if (m_fast == 0) return m_cnt;
    return (m_duty != 0) ? 9 * m_cnt : m_cnt;
  endfunction

  task automatic model_step();
    bit line, act;
    line = (m_state != 1) && !stretch;
    act = enable && run && (m_cnt != 0);
    m_tick = 0;
    case (m_state)
      0: if (act) begin m_state = 1; m_left = lo_len() - 1; end
      1: if (!act) m_state = 0;
         else if (m_left == 0) m_state = 2;
         else m_left--;
      2: if (!act) m_state = 0;
         else if (line) begin m_state = 3; m_left = hi_len() - 1; m_tick = 1; end
      default: if (!act) m_state = 0;
         else if (m_left == 0) begin m_state = 1; m_left = lo_len() - 1; end
         else m_left--;
    endcase
    if (cfg_we && !enable) begin
      m_fast = cfg_fast; m_duty = cfg_duty; m_cnt = cfg_count;
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, {scl_oe, scl_high, high_tick} == {m_state == 1, m_state == 3, m_tick},
        {scl_oe, scl_high, high_tick}, {m_state == 1, m_state == 3, m_tick});
    if (scl_oe) low_run++;
    else if (low_run > 0) begin last_low = low_run; low_run = 0; end
    if (scl_high) high_run++;
    else if (high_run > 0) begin last_high = high_run; high_run = 0; end
    if (high_tick) ticks++;
  endtask

  task automatic steps(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic write_cfg(string tag, bit f, bit d, int c);
    cfg_we = 1; cfg_fast = f; cfg_duty = d; cfg_count = 12'(c);
    step(tag);
    cfg_we = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; cfg_we = 0; cfg_fast = 0; cfg_duty = 0;
    cfg_count = '0; run = 0; stretch = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {scl_oe, scl_high, high_tick} == 3'b000,
        {scl_oe, scl_high, high_tick}, 0);
    rst_n = 1;
    steps("R1", 4);
    // R1: zero config from reset gives no clock
    enable = 1; run = 1;
    ticks = 0;
    steps("R1", 12);
    chk("R1 no ticks from reset config", ticks == 0, ticks, 0);

    // R4 standard mode N=3
    enable = 0; step("R9");
    chk("R9 released on disable", !scl_oe && !scl_high, scl_oe, 0);
    write_cfg("R4", 0, 0, 3);
    enable = 1; ticks = 0;
    steps("R4", 30);
    chk("R4 low length", last_low == 3, last_low, 3);
    chk("R4 high length", last_high == 3, last_high, 3);
    chk("R8 ticks seen", ticks >= 3, ticks, 3);

    // R2 write while enabled ignored
    write_cfg("R2", 1, 1, 7);
    steps("R2", 24);
    chk("R2 low unchanged", last_low == 3, last_low, 3);
    chk("R2 high unchanged", last_high == 3, last_high, 3);

    // R5 fast duty 0, N=2
    enable = 0; step("R9");
    write_cfg("R5", 1, 0, 2);
    enable = 1;
    steps("R5", 30);
    chk("R5 low length", last_low == 4, last_low, 4);
    chk("R5 high length", last_high == 2, last_high, 2);

    // R6 fast duty 1, N=1
    enable = 0; step("R9");
    write_cfg("R6", 1, 1, 1);
    enable = 1;
    steps("R6", 60);
    chk("R6 low length", last_low == 16, last_low, 16);
    chk("R6 high length", last_high == 9, last_high, 9);

    // R7 slave holds the line low
    stretch = 1;
    steps("R7", 40);
    chk("R7 waiting released", !scl_oe && !scl_high, {scl_oe, scl_high}, 0);
    ticks = 0;
    steps("R7", 5);
    chk("R7 no tick while held", ticks == 0, ticks, 0);
    stretch = 0;
    steps("R7", 30);
    chk("R7 high length after stretch", last_high == 9, last_high, 9);

    // R9 run withdrawn then restarted
    while (!scl_oe) step("R9");
    steps("R9", 3);
    run = 0; step("R9");
    chk("R9 run drop releases", !scl_oe && !scl_high, {scl_oe, scl_high}, 0);
    steps("R9", 3);
    run = 1;
    steps("R9", 20);
    chk("R9 full low after restart", last_low == 16, last_low, 16);

    // R10 duty ignored in standard mode
    enable = 0; step("R9");
    write_cfg("R10", 0, 1, 2);
    enable = 1;
    steps("R10", 25);
    chk("R10 low length", last_low == 2, last_low, 2);
    chk("R10 high length", last_high == 2, last_high, 2);

    // R3 zero count
    enable = 0; step("R9");
    write_cfg("R3", 1, 1, 0);
    enable = 1; ticks = 0; low_run = 0;
    steps("R3", 20);
    chk("R3 no ticks", ticks == 0, ticks, 0);
    chk("R3 line released", low_run == 0, low_run, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule